// File: doc/BRIEF.md
# Packed Lane Sign and Permute Unit

A 128-bit lane-parallel datapath that applies one of four operations to two operands. Two work per element at a selectable width of 8, 16 or 32 bits: a magnitude operation and a sign-steered negate/pass/zero operation. Two work at byte granularity: a table lookup that can zero individual bytes, and an alignment that joins the two operands and extracts a byte-shifted window.

The computation is combinational. The result is captured in an output register when the input strobe is high, and the valid flag rises in the same cycle that the new result appears. A surrounding pipeline issues one operation per cycle and reads the result one clock later.

Top module: `lane_permute_unit`

## Requirements
- R1: Opcode encoding: `op_sel` 0 selects magnitude, 1 selects sign-steer, 2 selects shuffle and 3 selects align. `elem_sz` 0 selects 8-bit elements, 1 selects 16-bit elements and 2 or 3 selects 32-bit elements. `elem_sz` affects only opcodes 0 and 1.
- R2: Magnitude (op 0) reads each element of `opnd_a` as signed and returns its absolute value as an unsigned element of the same width. The most negative element returns its own bit pattern, for example 0x80 for an 8-bit element.
- R3: Sign-steer (op 1) looks at the matching element of `opnd_b`. If that element is negative, the result is the two's complement of the `opnd_a` element. If it is zero, the result is zero. If it is positive, the result is the `opnd_a` element unchanged. Negating the most negative element wraps to the same value and does not saturate.
- R4: Shuffle (op 2) sets each result byte i from control byte i of `opnd_b`. If bit 7 of the control byte is 1, result byte i is 0x00. Otherwise result byte i is byte [3:0] of `opnd_a`, where byte 0 is bits [7:0].
- R5: For shuffle, bits [6:4] of each control byte have no effect on the result.
- R6: Align (op 3) forms the 256-bit value {`opnd_a`, `opnd_b`}, with `opnd_a` in the upper half. It shifts this value right by `shift_bytes`×8 bits and returns the low 128 bits.
- R7: When `in_valid` is high at a clock edge, `res` takes the value computed from the inputs at that edge. `res` then holds that value until the next edge at which `in_valid` is high.
- R8: `out_valid` is high in exactly the cycle that follows a clock edge at which `in_valid` was high.
- R9: While `rst_n` is low, `res` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe |
| op_sel | input | 2 | Operation select |
| elem_sz | input | 2 | Element width select |
| shift_bytes | input | 4 | Byte shift count for align |
| opnd_a | input | 128 | Data operand, and upper half of the concatenation for align |
| opnd_b | input | 128 | Control operand, and lower half of the concatenation for align |
| res | output | 128 | Registered result |
| out_valid | output | 1 | Result-valid flag |

## Verification
Random operands are run through all operation and width pairs, and each result is compared with a reference model in the bench. The directed cases cover the following:
- Control elements equal to zero, and data elements at the most negative value. These separate the zero and wrap branches from the plain negate.
- Shuffle controls with bits [6:4] set, and controls with bit 7 set. These show whether stray index bits or the clear bit leak into the result.
- Align shifts of 0 and 15. These confirm which operand forms the upper half.
- Gaps in the strobe. These confirm that the result register holds its value and that `out_valid` drops.

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op_sel,
  input  logic [1:0]   elem_sz,
  input  logic [3:0]   shift_bytes,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res,
  output logic         out_valid
);
  localparam int NB = W / 8;
  localparam int NH = W / 16;
  localparam int NW = W / 32;

  logic [W-1:0] abs8, abs16, abs32, sgn8, sgn16, sgn32, shuf, algn, nxt;
  logic [2*W-1:0] cat;

  for (genvar i = 0; i < NB; i++) begin : g_b
    logic [7:0] a, b;
    assign a = opnd_a[8*i +: 8];
    assign b = opnd_b[8*i +: 8];
    assign abs8[8*i +: 8] = a[7] ? -a : a;
    assign sgn8[8*i +: 8] = b[7] ? -a : (b == 8'd0 ? 8'd0 : a);
    assign shuf[8*i +: 8] = b[7] ? 8'd0 : opnd_a[8*b[3:0] +: 8];
  end

  for (genvar i = 0; i < NH; i++) begin : g_h
    logic [15:0] a, b;
    assign a = opnd_a[16*i +: 16];
    assign b = opnd_b[16*i +: 16];
    assign abs16[16*i +: 16] = a[15] ? -a : a;
    assign sgn16[16*i +: 16] = b[15] ? -a : (b == 16'd0 ? 16'd0 : a);
  end

  for (genvar i = 0; i < NW; i++) begin : g_w
    logic [31:0] a, b;
    assign a = opnd_a[32*i +: 32];
    assign b = opnd_b[32*i +: 32];
    assign abs32[32*i +: 32] = a[31] ? -a : a;
    assign sgn32[32*i +: 32] = b[31] ? -a : (b == 32'd0 ? 32'd0 : a);
  end

  assign cat  = {opnd_a, opnd_b} >> {shift_bytes, 3'b000};
  assign algn = cat[W-1:0];

  always_comb begin
    case (op_sel)
      2'd0:    nxt = (elem_sz == 2'd0) ? abs8 : (elem_sz == 2'd1) ? abs16 : abs32;
      2'd1:    nxt = (elem_sz == 2'd0) ? sgn8 : (elem_sz == 2'd1) ? sgn16 : sgn32;
      2'd2:    nxt = shuf;
      default: nxt = algn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end
endmodule

// File: rtl/lane_permute_unit_chk.sv
module lane_permute_unit_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   op_sel,
  input logic [3:0]   shift_bytes,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] res,
  input logic         out_valid
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res)); // R7
  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3 && shift_bytes == 4'd0) |=> res == $past(opnd_b)); // R6
  AST_SHUF_ALLCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2 && (opnd_b & {(W/8){8'h80}}) == {(W/8){8'h80}})
      |=> res == '0); // R4
  AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd1 && opnd_b == '0) |=> res == '0); // R3
  AST_RESET: assert property (@(posedge clk)
    !rst_n |=> (res == '0 && !out_valid)); // R9
endmodule

bind lane_permute_unit lane_permute_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .shift_bytes(shift_bytes), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .res(res), .out_valid(out_valid)
);

// File: tb/lane_permute_unit_tb.sv
module lane_permute_unit_tb;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] op_sel = 0, elem_sz = 0;
  logic [3:0] shift_bytes = 0;
  logic [127:0] opnd_a = 0, opnd_b = 0, res;
  logic out_valid;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  lane_permute_unit u_dut (.*);

  function automatic logic [127:0] model(logic [1:0] op, logic [1:0] sz, logic [3:0] sh,
                                         logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    logic [255:0] c;
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    case (op)
      2'd0, 2'd1: for (int i = 0; i < 128 / w; i++) begin
        longint av = 0, bv = 0, rv;
        for (int k = 0; k < w; k++) begin
          av[k] = a[i*w+k];
          bv[k] = b[i*w+k];
        end
        if (av[w-1]) av = av - (longint'(1) << w);
        if (bv[w-1]) bv = bv - (longint'(1) << w);
        if (op == 0) rv = (av < 0) ? -av : av;
        else rv = (bv < 0) ? -av : (bv == 0) ? 0 : av;
        for (int k = 0; k < w; k++) r[i*w+k] = rv[k];
      end
      2'd2: for (int i = 0; i < 16; i++) begin
        int idx = int'(b[8*i +: 4]);
        r[8*i +: 8] = b[8*i+7] ? 8'h00 : a[8*idx +: 8];
      end
      default: begin
        c = {a, b};
        for (int i = 0; i < 16; i++) begin
          int s = i + int'(sh);
          r[8*i +: 8] = c[8*s +: 8];
        end
      end
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [1:0] op, logic [1:0] sz, logic [3:0] sh,
                     logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    op_sel = op; elem_sz = sz; shift_bytes = sh; opnd_a = a; opnd_b = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(tag, res, model(op, sz, sh, a, b));
    chk("R8 valid", {127'd0, out_valid}, 128'd1);
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] hold, ra, rb;
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    chk("R9 reset res", res, '0);
    chk("R9 reset valid", {127'd0, out_valid}, '0);
    rst_n = 1;
    run("R2 abs8 min", 0, 0, 0, {16{8'h80}}, '0);
    chk("R2 abs8 min value", res, {16{8'h80}});
    run("R2 abs16", 0, 1, 0, {8{16'hFFFF}}, '0);
    chk("R2 abs16 value", res, {8{16'h0001}});
    run("R2 abs32 min", 0, 2, 0, {4{32'h80000000}}, '0);
    run("R3 sign zero ctl", 1, 0, 0, rnd(), '0);
    chk("R3 sign zero value", res, '0);
    run("R3 sign neg wrap", 1, 1, 0, {8{16'h8000}}, {8{16'hFFFF}});
    chk("R3 wrap value", res, {8{16'h8000}});
    run("R3 sign mix32", 1, 3, 0, {4{32'd5}}, {32'hFFFFFFFF, 32'd0, 32'd7, 32'h80000000});
    chk("R3 mix32 value", res, {32'hFFFFFFFB, 32'd0, 32'd5, 32'hFFFFFFFB});
    ra = rnd();
    run("R4 shuf clear", 2, 0, 0, ra, {16{8'h80}});
    chk("R4 clear value", res, '0);
    run("R5 shuf ignore", 2, 0, 0, ra, {16{8'h73}});
    chk("R5 ignore value", res, {16{ra[8*3 +: 8]}});
    run("R6 align 0", 3, 0, 0, ra, 128'h1234);
    chk("R6 align 0 value", res, 128'h1234);
    run("R6 align 15", 3, 0, 15, ra, {8'hAB, 120'd0});
    chk("R6 align 15 value", res, {ra[119:0], 8'hAB});
    run("R1 elem_sz ignored shuf", 2, 2, 0, ra, {16{8'h01}});
    hold = res;
    @(negedge clk);
    opnd_a = rnd();
    @(negedge clk);
    chk("R7 hold", res, hold);
    chk("R8 valid low", {127'd0, out_valid}, '0);
    for (int n = 0; n < 400; n++) begin
      logic [1:0] op = 2'($urandom);
      logic [1:0] sz = 2'($urandom);
      logic [3:0] sh = 4'($urandom);
      ra = rnd(); rb = rnd();
      if (n % 7 == 0) rb[31:0] = '0;
      run("R1 random", op, sz, sh, ra, rb);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule